// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Tick Generator

This block produces the timing pulses that one serial channel uses to shift its bits. It divides the peripheral clock in three stages. A power-of-four prescaler comes first. An 8-bit reload counter follows, and it divides by the programmed rate value N plus one. A fixed divider comes last, and its length depends on the operating mode. The output is a one-cycle bit tick per bit period. In the asynchronous modes the block also gives a one-cycle oversampling tick at 16 or 8 times the bit rate.

The rate value sits in an 8-bit register behind a simple register port. The register can always be read. Software can change it only while the channel's transmitter and receiver are both disabled. While both are disabled, every counter is held at zero. Counting starts from a clean state on the first clock edge at which either enable is high. The mode, the clock select, the half-rate select and the smart-card divisor are expected to stay stable while the channel is enabled.

Top module: `rate_tick_gen`

## Requirements
- R1: After reset the rate register reads 0xFF on `reg_rdata`.
- R2: A `reg_wr` pulse loads `reg_wdata` into the rate register only when `tx_en` and `rx_en` are both 0. Otherwise the write is ignored and `reg_rdata` keeps its old value.
- R3: `clk_sel` sets the prescale factor P to 1 for 00, 4 for 01, 16 for 10 and 64 for 11. Every bit period below scales with P × (N+1).
- R4: `mode_sel` 00 or 11 (asynchronous) with `half_rate`=0 gives a bit period of 32·P·(N+1) clocks. `os_tick` fires every 2·P·(N+1) clocks, 16 times per bit, and one of those pulses coincides with each `bit_tick`.
- R5: `mode_sel` 00 with `half_rate`=1 gives a bit period of 16·P·(N+1) clocks. `os_tick` fires 8 times per bit.
- R6: `mode_sel` 01 (clock-synchronous) gives a bit period of 4·P·(N+1) clocks, and `os_tick` stays 0.
- R7: `mode_sel` 10 (smart card) gives a bit period of 2·S·P·(N+1) clocks, where S = `sc_div` is even and at least 2. `os_tick` stays 0.
- R8: While `tx_en` and `rx_en` are both 0, no tick is produced and all counters are zero. When either enable rises, the first `bit_tick` is seen right after the T-th rising clock edge at which the enable is high, where T is the bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the rate register |
| reg_wdata | input | 8 | Write data for the rate register |
| reg_rdata | output | 8 | Current rate register value N |
| clk_sel | input | 2 | Prescaler select (÷1, ÷4, ÷16, ÷64) |
| mode_sel | input | 2 | 00/11 asynchronous, 01 clock-synchronous, 10 smart card |
| half_rate | input | 1 | Asynchronous half-length bit period (8× oversampling) |
| sc_div | input | 10 | Smart card divisor S (even) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| os_tick | output | 1 | One-cycle oversampling pulse (asynchronous only) |

## Verification
A wrong count in the prescaler, the reload counter or the fixed divider changes the spacing of `bit_tick`, so the first measured interval exposes it. A count that is not cleared when the enables drop shows up as a wrong first-tick latency, within one bit period of the enable rising. A wrong oversampling phase or length shows as the wrong number of `os_tick` pulses between two bit ticks. A write that slips through while the channel is enabled is visible on `reg_rdata` one cycle later.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   typedef enum logic [1:0] {
      MODE_ASYNC     = 2'b00,
      MODE_SYNC      = 2'b01,
      MODE_CARD      = 2'b10,
      MODE_ASYNC_ALT = 2'b11
   } rtg_mode_e;

   localparam int ASYNC_FULL_LEN = 32;
   localparam int ASYNC_HALF_LEN = 16;
   localparam int SYNC_LEN       = 4;
endpackage

// File: rtl/rtg_rate_reg.sv
module rtg_rate_reg #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [RATE_W-1:0] wdata,
   input  logic              locked,
   output logic [RATE_W-1:0] rate
);
   generate
      if (RATE_W < 1 || RATE_W > 16) begin : g_bad_w
         $error("rtg_rate_reg: RATE_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               rate <= '1;
      else if (wr && !locked)   rate <= wdata;
   end

   // R2: the value cannot move while the channel is enabled
   a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(rate));
   // R1: reset value is all ones
   a_r1_reset_ones: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rate == {RATE_W{1'b1}}));
endmodule

// File: rtl/rtg_prescaler.sv
module rtg_prescaler #(
   parameter int SEL_W     = 2,
   parameter int STEP_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             pre_tick
);
   localparam int PRE_W = STEP_LOG2 * ((1 << SEL_W) - 1);

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("rtg_prescaler: SEL_W out of range");
      end
      if (STEP_LOG2 < 1 || PRE_W > 24) begin : g_bad_step
         $error("rtg_prescaler: prescale range too large");
      end

      if (PRE_W == 0) begin : g_bypass
         assign pre_tick = en;
      end else begin : g_count
         logic [PRE_W-1:0] pc;
         logic [PRE_W-1:0] pc_last;

         assign pc_last  = PRE_W'((64'd1 << (STEP_LOG2 * int'(sel))) - 64'd1);
         assign pre_tick = en && (pc == pc_last);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pc <= '0;
            else if (!en)      pc <= '0;
            else if (pre_tick) pc <= '0;
            else               pc <= pc + 1'b1;
         end

         // R8: prescaler is cleared while idle
         a_r8_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> (pc == '0));
      end
   endgenerate
endmodule

// File: rtl/rtg_reload_ctr.sv
module rtg_reload_ctr #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              step,
   input  logic [RATE_W-1:0] limit,
   output logic              unit
);
   logic [RATE_W-1:0] rc;

   assign unit = en && step && (rc == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rc <= '0;
      else if (!en)      rc <= '0;
      else if (unit)     rc <= '0;
      else if (step)     rc <= rc + 1'b1;
   end

   // R8: reload counter is cleared while idle
   a_r8_rc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (rc == '0));
   // R3: counter never passes the programmed limit (limit is frozen while enabled)
   a_r3_rc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (rc <= limit));
endmodule

// File: rtl/rtg_fixed_div.sv
module rtg_fixed_div #(
   parameter int FIX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic [FIX_W-1:0] last,
   input  logic             async_mode,
   output logic             bit_pulse,
   output logic             os_pulse
);
   logic [FIX_W-1:0] fc;
   logic             wrap;

   generate
      if (FIX_W < 6) begin : g_bad_fix
         $error("rtg_fixed_div: FIX_W must hold the asynchronous length");
      end
   endgenerate

   assign wrap = en && step && (fc == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fc <= '0;
      else if (!en)      fc <= '0;
      else if (wrap)     fc <= '0;
      else if (step)     fc <= fc + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_pulse <= 1'b0;
         os_pulse  <= 1'b0;
      end else begin
         bit_pulse <= wrap;
         os_pulse  <= en && step && async_mode && fc[0];
      end
   end

   // R8: no output pulses one cycle after being idle
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!bit_pulse && !os_pulse));
   // R6 / R7: oversampling only in asynchronous modes
   a_r6_no_os_other_modes: assert property (@(posedge clk) disable iff (!rst_n)
      !async_mode |=> !os_pulse);
   // R4: each bit tick coincides with an oversampling tick in asynchronous mode
   a_r4_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_pulse && $past(async_mode)) |-> os_pulse);
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
   import rtg_pkg::*;
#(
   parameter int RATE_W    = 8,
   parameter int SEL_W     = 2,
   parameter int STEP_LOG2 = 2,
   parameter int SDIV_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [RATE_W-1:0] reg_wdata,
   output logic [RATE_W-1:0] reg_rdata,
   input  logic [SEL_W-1:0]  clk_sel,
   input  logic [1:0]        mode_sel,
   input  logic              half_rate,
   input  logic [SDIV_W-1:0] sc_div,
   input  logic              tx_en,
   input  logic              rx_en,
   output logic              bit_tick,
   output logic              os_tick
);
   localparam int FIX_W = SDIV_W + 1;

   generate
      if (SDIV_W < 5) begin : g_bad_sdiv
         $error("rate_tick_gen: SDIV_W too small for the fixed divider");
      end
   endgenerate

   logic             chan_en;
   logic             pre_tick;
   logic             unit;
   logic             async_mode;
   logic [FIX_W-1:0] fix_last;
   rtg_mode_e        mode;

   assign chan_en    = tx_en || rx_en;
   assign mode       = rtg_mode_e'(mode_sel);
   assign async_mode = (mode == MODE_ASYNC) || (mode == MODE_ASYNC_ALT);

   always_comb begin
      unique case (mode)
         MODE_SYNC: fix_last = FIX_W'(SYNC_LEN - 1);
         MODE_CARD: fix_last = {sc_div, 1'b0} - 1'b1;
         default:   fix_last = half_rate ? FIX_W'(ASYNC_HALF_LEN - 1)
                                         : FIX_W'(ASYNC_FULL_LEN - 1);
      endcase
   end

   rtg_rate_reg #(.RATE_W(RATE_W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .wdata  (reg_wdata),
      .locked (chan_en),
      .rate   (reg_rdata)
   );

   rtg_prescaler #(.SEL_W(SEL_W), .STEP_LOG2(STEP_LOG2)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (chan_en),
      .sel      (clk_sel),
      .pre_tick (pre_tick)
   );

   rtg_reload_ctr #(.RATE_W(RATE_W)) u_reload (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (chan_en),
      .step  (pre_tick),
      .limit (reg_rdata),
      .unit  (unit)
   );

   rtg_fixed_div #(.FIX_W(FIX_W)) u_fixed (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (chan_en),
      .step       (unit),
      .last       (fix_last),
      .async_mode (async_mode),
      .bit_pulse  (bit_tick),
      .os_pulse   (os_tick)
   );

   // R8: ticks only appear while the channel is enabled
   a_r8_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick || os_tick) |-> $past(chan_en));
endmodule

// File: tb/rate_tick_gen_tb_top.sv
module rate_tick_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] clk_sel = '0;
   logic [1:0] mode_sel = '0;
   logic       half_rate = 1'b0;
   logic [9:0] sc_div = 10'd32;
   logic       tx_en = 1'b0;
   logic       rx_en = 1'b0;
   logic       bit_tick;
   logic       os_tick;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   rate_tick_gen dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .clk_sel(clk_sel), .mode_sel(mode_sel),
      .half_rate(half_rate), .sc_div(sc_div), .tx_en(tx_en), .rx_en(rx_en),
      .bit_tick(bit_tick), .os_tick(os_tick)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic        half;
      logic [1:0]  cks;
      logic [7:0]  n;
      logic [9:0]  s;
      logic [31:0] per;
      logic [4:0]  os;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b0, 2'd0, 8'd0,   10'd32,  32'd32,    5'd16},
      '{2'd0, 1'b0, 2'd1, 8'd3,   10'd32,  32'd512,   5'd16},
      '{2'd0, 1'b0, 2'd2, 8'd1,   10'd32,  32'd1024,  5'd16},
      '{2'd0, 1'b0, 2'd3, 8'd0,   10'd32,  32'd2048,  5'd16},
      '{2'd0, 1'b0, 2'd0, 8'd255, 10'd32,  32'd8192,  5'd16},
      '{2'd0, 1'b1, 2'd0, 8'd0,   10'd32,  32'd16,    5'd8},
      '{2'd0, 1'b1, 2'd1, 8'd2,   10'd32,  32'd192,   5'd8},
      '{2'd0, 1'b1, 2'd2, 8'd0,   10'd32,  32'd256,   5'd8},
      '{2'd0, 1'b1, 2'd3, 8'd1,   10'd32,  32'd2048,  5'd8},
      '{2'd1, 1'b0, 2'd0, 8'd0,   10'd32,  32'd4,     5'd0},
      '{2'd1, 1'b1, 2'd1, 8'd0,   10'd32,  32'd16,    5'd0},
      '{2'd1, 1'b0, 2'd2, 8'd5,   10'd32,  32'd384,   5'd0},
      '{2'd1, 1'b0, 2'd0, 8'd255, 10'd32,  32'd1024,  5'd0},
      '{2'd1, 1'b0, 2'd3, 8'd2,   10'd32,  32'd768,   5'd0},
      '{2'd2, 1'b0, 2'd0, 8'd0,   10'd32,  32'd64,    5'd0},
      '{2'd2, 1'b0, 2'd1, 8'd1,   10'd64,  32'd1024,  5'd0},
      '{2'd2, 1'b0, 2'd2, 8'd0,   10'd186, 32'd5952,  5'd0},
      '{2'd2, 1'b0, 2'd3, 8'd0,   10'd32,  32'd4096,  5'd0},
      '{2'd3, 1'b0, 2'd0, 8'd1,   10'd32,  32'd64,    5'd16}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic string mode_tag(input vec_t v);
      if (v.mode == 2'd1) return "R6/R3";
      if (v.mode == 2'd2) return "R7/R3";
      if (v.half && v.mode == 2'd0) return "R5/R3";
      return "R4/R3";
   endfunction

   task automatic write_rate(input logic [7:0] val);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic run_vec(input int idx);
      vec_t v = VECS[idx];
      int cnt = 0;
      int t1 = -1, t2 = -1, t3 = -1;
      int osn = 0;
      int limit = 3 * int'(v.per) + 20;
      @(negedge clk);
      tx_en = 1'b0;
      rx_en = 1'b0;
      write_rate(v.n);
      check(reg_rdata == v.n, "R2 write while idle", reg_rdata, v.n);
      mode_sel = v.mode;
      half_rate = v.half;
      clk_sel = v.cks;
      sc_div = v.s;
      @(negedge clk);
      if (idx % 2 == 0) tx_en = 1'b1; else rx_en = 1'b1;
      while (t3 < 0 && cnt < limit) begin
         @(posedge clk);
         #1;
         cnt++;
         if (t1 >= 0 && t2 < 0 && os_tick) osn++;
         if (bit_tick) begin
            if (t1 < 0) t1 = cnt;
            else if (t2 < 0) t2 = cnt;
            else t3 = cnt;
         end
      end
      check(t1 == int'(v.per), "R8 first tick latency", t1, int'(v.per));
      check((t2 - t1) == int'(v.per), mode_tag(v), t2 - t1, int'(v.per));
      check((t3 - t2) == int'(v.per), mode_tag(v), t3 - t2, int'(v.per));
      check(osn == int'(v.os), mode_tag(v), osn, int'(v.os));
      @(negedge clk);
      tx_en = 1'b0;
      rx_en = 1'b0;
   endtask

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      int quiet;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(reg_rdata == 8'hFF, "R1 reset value", reg_rdata, 8'hFF);
      check(!bit_tick && !os_tick, "R8 idle after reset", bit_tick, 0);

      for (int i = 0; i < NV; i++) run_vec(i);

      // R2: write ignored while transmitter enabled
      write_rate(8'h12);
      @(negedge clk);
      tx_en = 1'b1;
      write_rate(8'h77);
      @(negedge clk);
      check(reg_rdata == 8'h12, "R2 write with tx_en", reg_rdata, 8'h12);
      tx_en = 1'b0;
      rx_en = 1'b1;
      write_rate(8'h55);
      @(negedge clk);
      check(reg_rdata == 8'h12, "R2 write with rx_en", reg_rdata, 8'h12);
      tx_en = 1'b1;
      write_rate(8'h00);
      @(negedge clk);
      check(reg_rdata == 8'h12, "R2 write with both enables", reg_rdata, 8'h12);

      // R8: disabling stops ticks
      mode_sel = 2'd1;
      clk_sel = 2'd0;
      write_rate(8'h00);   // ignored, still 0x12
      repeat (200) @(negedge clk);
      tx_en = 1'b0;
      rx_en = 1'b0;
      quiet = 0;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk);
         #1;
         if (bit_tick || os_tick) quiet++;
      end
      check(quiet == 0, "R8 no ticks while disabled", quiet, 0);
      write_rate(8'h00);
      check(reg_rdata == 8'h00, "R2 write accepted after disable", reg_rdata, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule